// File: doc/BRIEF.md
# Flash Code Segment Write Guard

This block stands between the requester of program-memory writes and erases and the flash controller. For each request it decides whether the operation may go ahead. A granted request becomes a one-cycle enable to the flash controller, which carries the registered address and operation type. A refused request never reaches the flash. It gives a one-cycle refusal pulse and sets a sticky violation flag that software clears.

Protection comes from two sources. First, two global flags protect the whole of memory. Second, a configurable code segment sits on top of the global flags and can only add protection. An 8-bit page pointer names one 512-word page, and that page always belongs to the protected segment. A select bit anchors the segment either to address zero or to the top of implemented memory. When the segment is anchored to the bottom, a further bit can also protect the last implemented page, which holds the configuration words. All settings are captured while reset is held and stay frozen until the next reset.

Top module: `nvm_seg_guard`

## Requirements
- R1: While reset is held and on the first cycle after it, `flashEn`, `denyPulse` and `violation` are 0.
- R2: With `segDisable` = 1 and both global flags at 0, every address is granted.
- R3: The page index is `reqAddr[16:9]` (512 words per page). With the segment enabled and `segTopAnchor` = 0, pages 0 through `segPagePtr` inclusive are refused, and higher pages are granted unless R5 applies.
- R4: With the segment enabled and `segTopAnchor` = 1, every page from `segPagePtr` through the highest page index is refused, including the last implemented page. Pages below `segPagePtr` are granted. `segLastOpen` has no effect in this mode.
- R5: With the segment enabled, `segTopAnchor` = 0 and `segLastOpen` = 0, the last implemented page (index `LAST_PAGE`, default 191) is also refused. With `segLastOpen` = 1, that page follows R3 only.
- R6: If `gblWrProt` or `gblCodeProt` is 1, every request is refused, whatever the segment settings are.
- R7: A granted request raises `flashEn` for exactly the next cycle. In that cycle `flashAddr` and `flashOp` equal the request's address and operation (0 = row write, 1 = page erase), and `denyPulse` stays 0.
- R8: A refused request raises `denyPulse` for exactly the next cycle, keeps `flashEn` at 0 and sets `violation`. `violation` stays set until a cycle with `violClear` = 1. If a refusal and a clear happen in the same cycle, the flag ends up set.
- R9: The protection inputs are sampled on every clock edge while `rst` is 1. Changes to them after reset have no effect on decisions.
- R10: A cycle without `reqValid` produces neither `flashEn` nor `denyPulse` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; protection settings are captured while it is high |
| reqValid | input | 1 | Request strobe, one request per cycle |
| reqOp | input | 1 | Operation: 0 row write, 1 page erase |
| reqAddr | input | 17 | Requested word address |
| gblWrProt | input | 1 | Global write protect of all memory |
| gblCodeProt | input | 1 | Global code protect of all memory |
| segDisable | input | 1 | 1 turns segment protection off |
| segTopAnchor | input | 1 | 1 anchors the segment at the top of memory, 0 at address zero |
| segLastOpen | input | 1 | 0 also protects the last page when anchored at the bottom |
| segPagePtr | input | 8 | Boundary page of the segment (inclusive) |
| violClear | input | 1 | Clears the sticky violation flag |
| flashEn | output | 1 | One-cycle go to the flash controller |
| flashOp | output | 1 | Operation of the granted request |
| flashAddr | output | 17 | Address of the granted request |
| denyPulse | output | 1 | One-cycle refusal indication |
| violation | output | 1 | Sticky violation flag |

## Verification
On every cycle, the assertions check the following:
- grant and refusal are mutually exclusive;
- an idle cycle is followed by no output pulse;
- a refusal always leaves the violation flag set, and the flag persists until it is cleared;
- the captured settings never move outside reset;
- a global flag forces refusal;
- a grant carries the address that was requested.

Only the bench scenarios can show whether the protected region has the right shape. These scenarios check the following:
- the inclusive boundary page under each anchor;
- the extra last-page protection and the fact that it is ignored in top mode;
- the disable bit;
- the set-wins collision between a refusal and a clear;
- that setting changes made after reset have no effect.

// File: rtl/nvm_seg_guard_pkg.sv
package nvm_seg_guard_pkg;

  typedef enum logic {
    OP_ROW_WRITE  = 1'b0,
    OP_PAGE_ERASE = 1'b1
  } nvm_op_e;

  // Captured protection settings
  typedef struct packed {
    logic       gblWp;
    logic       gblCp;
    logic       segOff;
    logic       topAnchor;
    logic       lastOpen;
    logic [7:0] pagePtr;
  } prot_cfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic issue;
    logic refuse;
    logic clear;
  } guard_strobe_t;

endpackage

// File: rtl/nvm_seg_guard_dp.sv
module nvm_seg_guard_dp
  import nvm_seg_guard_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BITS  = 9,
  parameter int LAST_PAGE  = 191
) (
  input  logic              clk,
  input  logic              rst,
  input  prot_cfg_t         cfgIn,
  input  logic [ADDR_W-1:0] reqAddr,
  input  nvm_op_e           reqOp,
  input  guard_strobe_t     strobes,
  output logic              protHit,
  output logic [ADDR_W-1:0] flashAddr,
  output nvm_op_e           flashOp
);

  localparam int PAGE_W = ADDR_W - PAGE_BITS;
  localparam logic [PAGE_W-1:0] LastIdx = PAGE_W'(LAST_PAGE);

  prot_cfg_t          cfgQ;
  logic [PAGE_W-1:0]  pageIdx;
  logic [PAGE_W-1:0]  ptrIdx;
  logic               inLow;
  logic               inHigh;
  logic               onLast;
  logic               segHit;
  logic               gblHit;

  // Settings follow the inputs only while reset is held
  always_ff @(posedge clk) begin
    if (rst) cfgQ <= cfgIn;
  end

  assign pageIdx = reqAddr[ADDR_W-1:PAGE_BITS];
  assign ptrIdx  = PAGE_W'(cfgQ.pagePtr);
  assign inLow   = (pageIdx <= ptrIdx);
  assign inHigh  = (pageIdx >= ptrIdx);
  assign onLast  = (pageIdx == LastIdx);

  always_comb begin
    if (cfgQ.segOff)         segHit = 1'b0;
    else if (cfgQ.topAnchor) segHit = inHigh;
    else                     segHit = inLow | (~cfgQ.lastOpen & onLast);
  end

  assign gblHit  = cfgQ.gblWp | cfgQ.gblCp;
  assign protHit = gblHit | segHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      flashAddr <= '0;
      flashOp   <= OP_ROW_WRITE;
    end else if (strobes.issue) begin
      flashAddr <= reqAddr;
      flashOp   <= reqOp;
    end
  end

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(cfgQ))
    else $error("settings changed outside reset");

  p_global_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (cfgQ.gblWp || cfgQ.gblCp) |-> protHit)
    else $error("global flag did not force refusal");

  p_addr_follows_r7: assert property (@(posedge clk) disable iff (rst)
    strobes.issue |=> (flashAddr == $past(reqAddr)))
    else $error("granted address not carried");

endmodule

// File: rtl/nvm_seg_guard_ctrl.sv
module nvm_seg_guard_ctrl
  import nvm_seg_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          reqValid,
  input  logic          protHit,
  input  logic          violClear,
  output guard_strobe_t strobes,
  output logic          flashEn,
  output logic          denyPulse,
  output logic          violation
);

  always_comb begin
    strobes.issue  = reqValid & ~protHit;
    strobes.refuse = reqValid &  protHit;
    strobes.clear  = violClear;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flashEn   <= 1'b0;
      denyPulse <= 1'b0;
      violation <= 1'b0;
    end else begin
      flashEn   <= strobes.issue;
      denyPulse <= strobes.refuse;
      if (strobes.refuse)     violation <= 1'b1;
      else if (strobes.clear) violation <= 1'b0;
    end
  end

  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(flashEn && denyPulse))
    else $error("grant and refusal together");

  p_deny_flags_r8: assert property (@(posedge clk) disable iff (rst)
    denyPulse |-> violation)
    else $error("refusal without violation flag");

  p_viol_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (violation && !violClear) |=> violation)
    else $error("violation dropped without clear");

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> (!flashEn && !denyPulse))
    else $error("pulse without request");

endmodule

// File: rtl/nvm_seg_guard.sv
module nvm_seg_guard
  import nvm_seg_guard_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int PAGE_BITS = 9,
  parameter int LAST_PAGE = 191
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              gblWrProt,
  input  logic              gblCodeProt,
  input  logic              segDisable,
  input  logic              segTopAnchor,
  input  logic              segLastOpen,
  input  logic [7:0]        segPagePtr,
  input  logic              violClear,
  output logic              flashEn,
  output logic              flashOp,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              denyPulse,
  output logic              violation
);

  prot_cfg_t     cfgIn;
  guard_strobe_t strobes;
  logic          protHit;
  nvm_op_e       opIn;
  nvm_op_e       opOut;

  assign cfgIn = '{gblWp: gblWrProt, gblCp: gblCodeProt, segOff: segDisable,
                   topAnchor: segTopAnchor, lastOpen: segLastOpen,
                   pagePtr: segPagePtr};
  assign opIn    = nvm_op_e'(reqOp);
  assign flashOp = opOut;

  nvm_seg_guard_dp #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .LAST_PAGE (LAST_PAGE)
  ) i_dp (
    .clk       (clk),
    .rst       (rst),
    .cfgIn     (cfgIn),
    .reqAddr   (reqAddr),
    .reqOp     (opIn),
    .strobes   (strobes),
    .protHit   (protHit),
    .flashAddr (flashAddr),
    .flashOp   (opOut)
  );

  nvm_seg_guard_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .protHit   (protHit),
    .violClear (violClear),
    .strobes   (strobes),
    .flashEn   (flashEn),
    .denyPulse (denyPulse),
    .violation (violation)
  );

endmodule

// File: tb/test_nvm_seg_guard.sv
module test_nvm_seg_guard;

  localparam int AW   = 17;
  localparam int LAST = 191;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic          reqOp = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          gblWrProt = 1'b0, gblCodeProt = 1'b0;
  logic          segDisable = 1'b1, segTopAnchor = 1'b0, segLastOpen = 1'b1;
  logic [7:0]    segPagePtr = 8'd0;
  logic          violClear = 1'b0;
  logic          flashEn, flashOp, denyPulse, violation;
  logic [AW-1:0] flashAddr;

  int checks = 0;
  int fails  = 0;

  // Model copies of the captured settings
  bit mWp, mCp, mOff, mTop, mOpen;
  int mPtr;
  bit violExp = 1'b0;

  always #5 clk = ~clk;

  nvm_seg_guard #(.ADDR_W(AW), .PAGE_BITS(9), .LAST_PAGE(LAST)) i_nvm_seg_guard (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .gblWrProt(gblWrProt), .gblCodeProt(gblCodeProt), .segDisable(segDisable),
    .segTopAnchor(segTopAnchor), .segLastOpen(segLastOpen), .segPagePtr(segPagePtr),
    .violClear(violClear), .flashEn(flashEn), .flashOp(flashOp),
    .flashAddr(flashAddr), .denyPulse(denyPulse), .violation(violation)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit expBlock(input logic [AW-1:0] a);
    int pg;
    pg = int'(a[AW-1:9]);
    if (mWp || mCp) return 1'b1;
    if (mOff)       return 1'b0;
    if (mTop)       return pg >= mPtr;
    return (pg <= mPtr) || (!mOpen && pg == LAST);
  endfunction

  function automatic string cfgTag();
    if (mWp || mCp) return "R6";
    if (mOff)       return "R2";
    if (mTop)       return "R4";
    if (!mOpen)     return "R5";
    return "R3";
  endfunction

  task automatic applyCfg(input bit wp, input bit cp, input bit off,
                          input bit top, input bit open, input int ptr);
    @(negedge clk);
    gblWrProt = wp; gblCodeProt = cp; segDisable = off;
    segTopAnchor = top; segLastOpen = open; segPagePtr = 8'(ptr);
    rst = 1'b1; reqValid = 1'b0; violClear = 1'b0;
    repeat (2) @(negedge clk);
    chk(flashEn == 0 && denyPulse == 0 && violation == 0, "R1", "outputs in reset",
        {flashEn, denyPulse, violation}, 0);
    rst = 1'b0;
    mWp = wp; mCp = cp; mOff = off; mTop = top; mOpen = open; mPtr = ptr;
    violExp = 1'b0;
    @(negedge clk);
    chk(flashEn == 0 && denyPulse == 0 && violation == 0, "R1", "outputs after reset",
        {flashEn, denyPulse, violation}, 0);
  endtask

  task automatic doReq(input logic [AW-1:0] a, input bit op, input bit clr,
                       input string tag);
    bit b;
    b = expBlock(a);
    reqValid = 1'b1; reqAddr = a; reqOp = op; violClear = clr;
    if (b) violExp = 1'b1;
    else if (clr) violExp = 1'b0;
    @(negedge clk);
    chk(flashEn == !b, tag, "flashEn", flashEn, !b);
    chk(denyPulse == b, tag, "denyPulse", denyPulse, b);
    chk(violation == violExp, b ? "R8" : tag, "violation", violation, violExp);
    if (!b) begin
      chk(flashAddr == a, "R7", "flashAddr", flashAddr, a);
      chk(flashOp == op, "R7", "flashOp", flashOp, op);
    end
    reqValid = 1'b0; violClear = 1'b0;
  endtask

  task automatic idle(input bit clr);
    violClear = clr;
    if (clr) violExp = 1'b0;
    @(negedge clk);
    chk(flashEn == 0 && denyPulse == 0, "R10", "pulse on idle",
        {flashEn, denyPulse}, 0);
    chk(violation == violExp, "R8", "violation after idle", violation, violExp);
    violClear = 1'b0;
  endtask

  function automatic logic [AW-1:0] pgAddr(input int pg, input int off);
    return AW'(pg * 512 + off);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));

    // Bottom anchor, last page open
    applyCfg(0, 0, 0, 0, 1, 10);
    doReq(pgAddr(10, 511), 0, 0, "R3");
    doReq(pgAddr(11, 0), 1, 0, "R3");
    doReq(pgAddr(0, 0), 0, 0, "R3");
    doReq(pgAddr(LAST, 3), 1, 0, "R5");
    idle(0);
    idle(1);
    doReq(pgAddr(5, 0), 0, 1, "R8");   // refusal and clear together: set wins
    idle(0);
    // R9: change the inputs after reset; the captured settings still apply
    @(negedge clk);
    segTopAnchor = 1'b1; segPagePtr = 8'd0; gblWrProt = 1'b1;
    @(negedge clk);
    doReq(pgAddr(150, 7), 1, 1, "R9");
    doReq(pgAddr(9, 0), 0, 0, "R9");

    // Bottom anchor, last page protected
    applyCfg(0, 0, 0, 0, 0, 10);
    doReq(pgAddr(LAST, 0), 0, 0, "R5");
    doReq(pgAddr(LAST - 1, 511), 0, 0, "R5");
    doReq(pgAddr(LAST + 1, 0), 0, 0, "R5");

    // Top anchor; segLastOpen has no effect
    applyCfg(0, 0, 0, 1, 1, 100);
    doReq(pgAddr(99, 511), 1, 0, "R4");
    doReq(pgAddr(100, 0), 0, 0, "R4");
    doReq(pgAddr(LAST, 0), 0, 0, "R4");
    doReq(pgAddr(255, 511), 0, 0, "R4");

    // Segment off
    applyCfg(0, 0, 1, 0, 0, 200);
    doReq(pgAddr(0, 0), 0, 0, "R2");
    doReq(pgAddr(LAST, 0), 1, 0, "R2");

    // Global flags
    applyCfg(1, 0, 1, 0, 1, 0);
    doReq(pgAddr(50, 1), 0, 0, "R6");
    applyCfg(0, 1, 0, 1, 1, 200);
    doReq(pgAddr(0, 0), 1, 0, "R6");

    // Random settings and requests, biased towards boundary pages
    for (int c = 0; c < 8; c++) begin
      applyCfg(($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 4) == 0,
               $urandom % 2, $urandom % 2, $urandom % 256);
      for (int n = 0; n < 250; n++) begin
        int pg;
        case ($urandom % 5)
          0: pg = mPtr - 1;
          1: pg = mPtr;
          2: pg = mPtr + 1;
          3: pg = LAST;
          default: pg = $urandom % 256;
        endcase
        if (pg < 0) pg = 0;
        if (pg > 255) pg = 255;
        if (($urandom % 8) == 0) idle(($urandom % 3) == 0);
        else doReq(pgAddr(pg, $urandom % 512), $urandom % 2,
                   ($urandom % 10) == 0, cfgTag());
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule